// File: doc/BRIEF.md
# Quadrature Envelope Detector with Logarithmic Compression

This block turns a stream of demodulated in-phase/quadrature sample pairs into display-ready echo brightness. For each signed pair it forms the sum of squares in a 33-bit accumulator and takes the 16-bit integer square root of that sum. It then converts the magnitude into an 8-bit brightness code through a logarithmic compression table.

The square root is split between a table and an iteration. A 4096-entry seed table, addressed by the twelve upper bits of the 32-bit sum, supplies the six top bits of the root. A bit-serial loop then settles the ten low bits one per cycle, from the most significant down. The loop runs over several cycles, so the block works on one sample at a time: it drops its input ready when it accepts a pair and raises it again only after the result has left on the output stream. Both tables are RAMs that are loaded through a shared write port before use.

Top module: `qenv_detector`

## Requirements
- R1: After reset, in_ready is 1 and out_valid is 0.
- R2: The sum of squares is formed without overflow for every pair of 16-bit signed inputs, including -32768 on both inputs, which gives a magnitude of 46340.
- R3: When seed table entry k holds floor(sqrt(k)) for every k, out_mag equals floor(sqrt(I*I + Q*Q)) exactly.
- R4: The seed table is addressed by bits 31..20 of the sum of squares, and its entry supplies root bits 15..10. The ten low bits are then decided in exactly ten steps, bit 9 first. Each step keeps a bit only if the square of the candidate does not exceed the sum. When every seed entry is 0, out_mag is therefore min(floor(sqrt(I*I+Q*Q)), 1023).
- R5: out_log equals the compression table entry addressed by the upper LOG_AW bits of out_mag, which are bits 15..6 with the default LOG_AW of 10.
- R6: I = Q = 0 yields out_mag = 0 and out_log = compression entry 0.
- R7: After a pair is accepted, in_ready stays 0 until the result is taken (out_valid and out_ready both 1). Results leave in the order the pairs arrived.
- R8: While out_valid is 1 and out_ready is 0, out_valid, out_mag and out_log hold their values.
- R9: A write with tbl_we = 1 and tbl_sel = 0 stores tbl_data[5:0] into seed entry tbl_addr[11:0]. A write with tbl_sel = 1 stores tbl_data[7:0] into compression entry tbl_addr[LOG_AW-1:0]. Samples accepted after a write use the new contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input pair available |
| in_ready | output | 1 | Block idle and accepting a pair |
| in_i | input | 16 | In-phase sample, two's complement |
| in_q | input | 16 | Quadrature sample, two's complement |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer accepts the result |
| out_mag | output | 16 | Integer envelope magnitude |
| out_log | output | 8 | Log-compressed brightness code |
| tbl_we | input | 1 | Table write strobe |
| tbl_sel | input | 1 | Table select: 0 seed, 1 compression |
| tbl_addr | input | 12 | Table write address |
| tbl_data | input | 8 | Table write data |

## Verification
Under a correct seed table the refinement loop only ever corrects bits below bit 10, so a fault in how it treats the upper bits stays hidden. The bench reaches that case by rewriting the whole seed table with zeros in mid-run. The ten steps then have to build large roots on their own, and results must saturate at 1023. Extreme inputs, -32768 on both channels and a sum just under a perfect square, exercise the accumulator width and the not-greater-than comparison. Random pairs run under random output stalls, which exercises the holding of results.

// File: rtl/qenv_pkg.sv
package qenv_pkg;
    localparam int IQ_W        = 16;
    localparam int ROOT_W      = 16;
    localparam int SQ_W        = 2 * IQ_W;
    localparam int SUM_W       = SQ_W + 1;
    localparam int SEED_BITS   = 6;
    localparam int FINE_BITS   = ROOT_W - SEED_BITS;
    localparam int SEED_AW     = 2 * SEED_BITS;
    localparam int STEP_W      = $clog2(FINE_BITS);
    localparam int LOG_DW      = 8;

    typedef struct packed {
        logic signed [IQ_W-1:0] i;
        logic signed [IQ_W-1:0] q;
    } iq_pair_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SUM,
        ST_SEEDRD,
        ST_START,
        ST_REFINE,
        ST_LOGRD,
        ST_OUT
    } det_state_t;

    function automatic logic [SQ_W-1:0] square_of(input logic signed [IQ_W-1:0] v);
        logic signed [SQ_W-1:0] ext;
        logic signed [SQ_W-1:0] prod;
        ext  = {{IQ_W{v[IQ_W-1]}}, v};
        prod = ext * ext;
        return prod;
    endfunction
endpackage

// File: rtl/qenv_sumsq.sv
module qenv_sumsq
    import qenv_pkg::*;
(
    input  iq_pair_t         pair,
    output logic [SUM_W-1:0] sum
);
    logic [SQ_W-1:0] sq_i;
    logic [SQ_W-1:0] sq_q;

    always_comb begin
        sq_i = square_of(pair.i);
        sq_q = square_of(pair.q);
        sum  = {1'b0, sq_i} + {1'b0, sq_q};
    end
endmodule

// File: rtl/qenv_table.sv
module qenv_table #(
    parameter int AW = 10,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst)      rdata <= '0;
        else if (re)  rdata <= mem[raddr];
    end
endmodule

// File: rtl/qenv_refine.sv
module qenv_refine
    import qenv_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic [SUM_W-1:0]     sum,
    input  logic [SEED_BITS-1:0] seed,
    output logic                 busy,
    output logic                 done,
    output logic [ROOT_W-1:0]    root
);
    logic [STEP_W-1:0] step_q;
    logic [ROOT_W-1:0] trial;
    logic [SQ_W-1:0]   trial_sq;
    logic              keep;

    always_comb begin
        trial    = root | (ROOT_W'(1) << step_q);
        trial_sq = SQ_W'(trial) * SQ_W'(trial);
        keep     = ({1'b0, trial_sq} <= sum);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            root   <= '0;
            step_q <= '0;
            busy   <= 1'b0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                root   <= {seed, {FINE_BITS{1'b0}}};
                step_q <= STEP_W'(FINE_BITS - 1);
                busy   <= 1'b1;
            end else if (busy) begin
                if (keep) root <= trial;
                if (step_q == '0) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end else begin
                    step_q <= step_q - 1'b1;
                end
            end
        end
    end

    logic [STEP_W:0] chk_steps;
    always_ff @(posedge clk) begin
        if (rst || start) chk_steps <= '0;
        else if (busy)    chk_steps <= chk_steps + 1'b1;
    end

    // R4: a result appears after exactly FINE_BITS refinement cycles
    p_ten_steps_r4: assert property (@(posedge clk) disable iff (rst)
        done |-> (chk_steps == (STEP_W+1)'(FINE_BITS)));

    // R3: the kept root never squares above the sum (valid seed contents)
    p_root_floor_r3: assert property (@(posedge clk) disable iff (rst)
        done |-> ({1'b0, SQ_W'(root) * SQ_W'(root)} <= sum));
endmodule

// File: rtl/qenv_detector.sv
module qenv_detector
    import qenv_pkg::*;
#(
    parameter int LOG_AW = 10,
    parameter int TBL_AW = (SEED_AW > LOG_AW) ? SEED_AW : LOG_AW
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   in_valid,
    output logic                   in_ready,
    input  logic signed [IQ_W-1:0] in_i,
    input  logic signed [IQ_W-1:0] in_q,
    output logic                   out_valid,
    input  logic                   out_ready,
    output logic [ROOT_W-1:0]      out_mag,
    output logic [LOG_DW-1:0]      out_log,
    input  logic                   tbl_we,
    input  logic                   tbl_sel,
    input  logic [TBL_AW-1:0]      tbl_addr,
    input  logic [LOG_DW-1:0]      tbl_data
);
    det_state_t          state;
    iq_pair_t            pair_q;
    logic [SUM_W-1:0]    sum_d;
    logic [SUM_W-1:0]    sum_q;
    logic [SEED_BITS-1:0] seed_rd;
    logic                ref_busy;
    logic                ref_done;
    logic [ROOT_W-1:0]   root;
    logic                fire_in;
    logic                fire_out;

    assign in_ready  = (state == ST_IDLE);
    assign out_valid = (state == ST_OUT);
    assign fire_in   = in_valid && in_ready;
    assign fire_out  = out_valid && out_ready;

    qenv_sumsq u_sumsq (
        .pair (pair_q),
        .sum  (sum_d)
    );

    qenv_table #(.AW(SEED_AW), .DW(SEED_BITS)) u_seed (
        .clk   (clk),
        .rst   (rst),
        .we    (tbl_we && !tbl_sel),
        .waddr (tbl_addr[SEED_AW-1:0]),
        .wdata (tbl_data[SEED_BITS-1:0]),
        .re    (state == ST_SEEDRD),
        .raddr (sum_q[SQ_W-1 -: SEED_AW]),
        .rdata (seed_rd)
    );

    qenv_refine u_refine (
        .clk   (clk),
        .rst   (rst),
        .start (state == ST_START),
        .sum   (sum_q),
        .seed  (seed_rd),
        .busy  (ref_busy),
        .done  (ref_done),
        .root  (root)
    );

    qenv_table #(.AW(LOG_AW), .DW(LOG_DW)) u_logtab (
        .clk   (clk),
        .rst   (rst),
        .we    (tbl_we && tbl_sel),
        .waddr (tbl_addr[LOG_AW-1:0]),
        .wdata (tbl_data),
        .re    (state == ST_LOGRD),
        .raddr (root[ROOT_W-1 -: LOG_AW]),
        .rdata (out_log)
    );

    assign out_mag = root;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            pair_q <= '0;
            sum_q  <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (fire_in) begin
                    pair_q <= '{i: in_i, q: in_q};
                    state  <= ST_SUM;
                end
                ST_SUM: begin
                    sum_q <= sum_d;
                    state <= ST_SEEDRD;
                end
                ST_SEEDRD: state <= ST_START;
                ST_START:  state <= ST_REFINE;
                ST_REFINE: if (ref_done) state <= ST_LOGRD;
                ST_LOGRD:  state <= ST_OUT;
                ST_OUT:    if (fire_out) state <= ST_IDLE;
                default:   state <= ST_IDLE;
            endcase
        end
    end

    // R2: the accumulated sum never reaches its guard bit
    p_no_overflow_r2: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SEEDRD) |-> !sum_q[SUM_W-1]);

    // R7: acceptance closes the input until the result is taken
    p_single_flight_r7: assert property (@(posedge clk) disable iff (rst)
        fire_in |=> !in_ready);

    // R7: the output only becomes valid after the refinement loop finished
    p_out_after_refine_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(out_valid) |-> !ref_busy);

    // R8: a stalled result stays put
    p_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_mag) && $stable(out_log)));
endmodule

// File: tb/tb_qenv_detector.sv
module tb_qenv_detector;
    localparam int LOG_AW = 10;

    logic               clk = 1'b0;
    logic               rst;
    logic               in_valid;
    logic               in_ready;
    logic signed [15:0] in_i;
    logic signed [15:0] in_q;
    logic               out_valid;
    logic               out_ready;
    logic [15:0]        out_mag;
    logic [7:0]         out_log;
    logic               tbl_we;
    logic               tbl_sel;
    logic [11:0]        tbl_addr;
    logic [7:0]         tbl_data;

    int total = 0;
    int bad   = 0;
    logic [7:0] logshadow [1024];

    always #10 clk = ~clk;

    qenv_detector #(.LOG_AW(LOG_AW)) dut (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_ready(in_ready), .in_i(in_i), .in_q(in_q),
        .out_valid(out_valid), .out_ready(out_ready), .out_mag(out_mag), .out_log(out_log),
        .tbl_we(tbl_we), .tbl_sel(tbl_sel), .tbl_addr(tbl_addr), .tbl_data(tbl_data)
    );

    function automatic int unsigned isqrt(input longint unsigned v);
        longint unsigned r = 0;
        for (int b = 15; b >= 0; b--) begin
            longint unsigned t = r | (64'd1 << b);
            if (t * t <= v) r = t;
        end
        return int'(r);
    endfunction

    function automatic logic [7:0] logref(input int k);
        return 8'(((k * 37) + 11) ^ (k >> 2));
    endfunction

    function automatic longint unsigned sumsq(input logic signed [15:0] a, input logic signed [15:0] b);
        longint signed x = a;
        longint signed y = b;
        return longint'(x * x + y * y);
    endfunction

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input bit sel, input int addr, input int data);
        @(negedge clk);
        tbl_we = 1'b1; tbl_sel = sel; tbl_addr = 12'(addr); tbl_data = 8'(data);
        @(negedge clk);
        tbl_we = 1'b0;
    endtask

    task automatic run(input logic signed [15:0] a, input logic signed [15:0] b,
                       input bit zero_seed, input int stall, input string tag);
        longint unsigned s = sumsq(a, b);
        int unsigned em = isqrt(s);
        logic [15:0] hm;
        logic [7:0]  hl;
        bit held = 1'b1;
        int guard = 0;
        if (zero_seed && em > 1023) em = 1023;
        @(negedge clk);
        in_valid = 1'b1; in_i = a; in_q = b;
        while (!in_ready && guard < 100) begin @(negedge clk); guard++; end
        @(negedge clk);
        in_valid = 1'b0;
        check(in_ready == 1'b0, "R7 busy after accept", in_ready, 0);
        guard = 0;
        while (!out_valid && guard < 100) begin
            if (in_ready) held = 1'b0;
            @(negedge clk); guard++;
        end
        check(held, "R7 ready low while busy", held, 1);
        hm = out_mag; hl = out_log;
        for (int c = 0; c < stall; c++) begin
            @(negedge clk);
            if (!out_valid || out_mag != hm || out_log != hl) held = 1'b0;
        end
        if (stall > 0) check(held, "R8 hold under stall", held, 1);
        check(out_valid && out_mag == 16'(em), tag, out_mag, em);
        check(out_log == logshadow[out_mag[15:6]], "R5 log lookup", out_log, logshadow[out_mag[15:6]]);
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
        check(!out_valid && in_ready, "R7 release after take", out_valid, 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst = 1'b1; in_valid = 1'b0; in_i = '0; in_q = '0; out_ready = 1'b0;
        tbl_we = 1'b0; tbl_sel = 1'b0; tbl_addr = '0; tbl_data = '0;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(in_ready == 1'b1, "R1 ready after reset", in_ready, 1);
        check(out_valid == 1'b0, "R1 no output after reset", out_valid, 0);

        // R9: load both tables
        for (int k = 0; k < 4096; k++) wr(1'b0, k, isqrt(longint'(k)));
        for (int k = 0; k < 1024; k++) begin
            logshadow[k] = logref(k);
            wr(1'b1, k, logref(k));
        end

        run(16'sd0, 16'sd0, 1'b0, 0, "R6 zero input");
        check(out_log == logref(0), "R6 zero log", out_log, logref(0));
        run(-16'sd32768, -16'sd32768, 1'b0, 2, "R2 most negative pair");
        run(16'sd32767, -16'sd32768, 1'b0, 0, "R2 mixed extremes");
        run(16'sd3, 16'sd4, 1'b0, 1, "R3 exact square 5");
        run(-16'sd1, -16'sd1, 1'b0, 0, "R3 root of 2");
        run(16'sd1000, 16'sd0, 1'b0, 0, "R3 on axis");
        run(16'sd6000, 16'sd8000, 1'b0, 0, "R4 seed boundary");
        run(16'sd181, 16'sd0, 1'b0, 3, "R3 below seed bit");

        for (int n = 0; n < 300; n++) begin
            logic signed [15:0] a = 16'($urandom);
            logic signed [15:0] b = 16'($urandom);
            if (n % 4 == 1) begin a = a >>> 8; b = b >>> 9; end
            run(a, b, 1'b0, int'($urandom % 4), "R3 random pair");
        end

        // R9: rewrite one compression entry, seen by later samples
        logshadow[78] = 8'hA5;
        wr(1'b1, 78, 8'hA5);
        run(16'sd5000, 16'sd0, 1'b0, 0, "R9 log rewrite mag");
        check(out_log == 8'hA5, "R9 rewritten log entry", out_log, 8'hA5);

        // R4: zero seed table, refinement alone saturates at 1023
        for (int k = 0; k < 4096; k++) wr(1'b0, k, 0);
        run(16'sd20000, 16'sd20000, 1'b0 | 1'b1, 0, "R4 zero seed large");
        run(16'sd600, 16'sd800, 1'b1, 0, "R4 zero seed small");
        run(16'sd1023, 16'sd0, 1'b1, 0, "R4 zero seed top");
        run(-16'sd32768, 16'sd5, 1'b1, 1, "R4 zero seed extreme");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule